// File: doc/BRIEF.md
# Frame-sync parallel video capture port

This block takes pixels from a parallel camera bus that marks frames with a vertical sync, marks lines with a horizontal sync and carries a field indicator. Once enabled, it waits for a vertical sync assertion. It then waits for a horizontal sync assertion taken while the field input is low, and that assertion opens the frame. On every horizontal sync assertion inside a frame, the port lets a programmed number of clocks pass. It then takes a programmed number of samples and goes quiet until the next horizontal sync. The port detects sync assertions as edges and latches them, so the syncs may drop again at once.

Samples are either 8 or 16 bits wide. In 8-bit mode the port can pack two samples into one 16-bit word, with the earlier sample in the low byte. Words go into a 16-entry first-word-fall-through FIFO whose non-empty flag acts as a service request to a downstream mover. Three configuration bits set the behaviour at the bus edge:

- The sync polarity bit makes both syncs active high or active low.
- The clock polarity bit selects whether the bus is sampled on the rising or the falling clock edge.
- The data length bit selects 8-bit or 16-bit samples.

Two sticky status bits are provided. One flags a frame whose line count differs from the programmed frame length. The other flags FIFO overruns.

Top module: `vcap_port`

## Requirements
- R1: While `en` is low, or while no vertical sync assertion has been seen since enabling, no sample is written. After a vertical sync assertion, a horizontal sync assertion taken with `vid_field` high does not open the frame; the first one taken with `vid_field` low does.
- R2: A sync assertion is the sampled transition from the inactive level to the active level. Capture goes on after the horizontal sync returns to inactive, so a sync needs to stay asserted for only one sampling clock.
- R3: The first sample of a line is the bus value `cfg_delay` sampling clocks after the clock in which the horizontal sync assertion is first sampled. Exactly `cfg_count`+1 consecutive samples are taken, and then nothing more until the next horizontal sync assertion.
- R4: With `cfg_sync_pol`=0 both syncs are active high. With `cfg_sync_pol`=1 both are active low.
- R5: With `cfg_clk_pol`=0 the bus is sampled on the rising clock edge. With `cfg_clk_pol`=1 it is sampled on the falling edge.
- R6: In 8-bit mode (`cfg_wide`=0) only `vid_data[7:0]` is used. Unpacked (`cfg_pack`=0), each sample becomes the word {8'h00, sample}. Packed (`cfg_pack`=1), sample pairs form the word {later, earlier}. A leftover odd sample at the end of a line is discarded.
- R7: In 16-bit mode (`cfg_wide`=1) each sample is stored as the full 16-bit bus word, and `cfg_pack` has no effect.
- R8: The FIFO holds 16 words in arrival order. `rd_data` shows the oldest word. `req` is high whenever the FIFO holds at least one word, and a cycle with `rd_en` high removes one word.
- R9: A word that arrives while the FIFO is full and no read takes place is dropped, and `ovr_err` is set. `ovr_err` stays set until `en` goes low.
- R10: When a vertical sync assertion ends an open frame, `ft_err` is set if the number of lines counted in that frame differs from `cfg_lines`. `ft_err` stays set until `en` goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Port enable; low also clears both status bits |
| cfg_sync_pol | input | 1 | 0: syncs active high, 1: syncs active low |
| cfg_clk_pol | input | 1 | 0: sample on rising edge, 1: sample on falling edge |
| cfg_pack | input | 1 | Pack sample pairs in 8-bit mode |
| cfg_wide | input | 1 | 0: 8-bit samples, 1: 16-bit samples |
| cfg_delay | input | 8 | Clocks between the horizontal sync assertion and the first sample |
| cfg_count | input | 12 | Samples per line minus one |
| cfg_lines | input | 12 | Expected lines per frame |
| vid_vs | input | 1 | Vertical sync |
| vid_hs | input | 1 | Horizontal sync |
| vid_field | input | 1 | Field indicator; must be low to open a frame |
| vid_data | input | 16 | Pixel data bus |
| rd_en | input | 1 | Pop the oldest FIFO word |
| rd_data | output | 16 | Oldest FIFO word |
| req | output | 1 | FIFO not empty |
| ft_err | output | 1 | Sticky frame line-count mismatch |
| ovr_err | output | 1 | Sticky FIFO overrun |

## Verification
The bench drives a deliberately wrong data value during the half clock that the selected edge should not sample. A port that sampled on the wrong edge would therefore store inverted pixels. Each pixel value encodes its line and its position within the line. A wrong delay or an off-by-one sample count would then show up as shifted or extra words, and a packer that swapped bytes or kept a stray odd sample would store words that do not match. The bench also checks the following cases:

- Lines sent before any vertical sync, and a line sent with the field input high, must leave the FIFO empty.
- A frame one line short must raise the frame-track flag.
- Twenty words pushed into a FIFO that is never read must leave exactly the first sixteen words and a set overrun flag.

// File: rtl/vcap_pkg.sv
// Package: shared types of the capture port.
package vcap_pkg;
    typedef enum logic [2:0] {
        S_WAITVS,   // enabled, waiting for a vertical sync assertion
        S_ARMED,    // vertical sync seen, waiting for a line with field low
        S_LWAIT,    // inside a frame, between lines
        S_DELAY,    // counting clocks before the first sample
        S_CAP       // taking samples
    } cap_state_t;
endpackage

// File: rtl/vcap_front.sv
// Module: vcap_front
// Samples the camera bus on the selected clock edge and turns the syncs into
// one-cycle assertion pulses. Assumes the configuration is static while the
// port is enabled. Both sampling paths deliver the same cycle's bus value.
module vcap_front #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_pol,
    input  logic              sync_pol,
    input  logic              vs,
    input  logic              hs,
    input  logic              field,
    input  logic [DATA_W-1:0] data,
    output logic              s_field,
    output logic [DATA_W-1:0] s_data,
    output logic              vs_edge,
    output logic              hs_edge
);
    localparam int BUS_W = DATA_W + 3;

    logic [BUS_W-1:0] p_bus, n_bus, sel_bus;
    logic             vs_act, hs_act, vs_prev, hs_prev;

    // rising-edge sampling path
    always_ff @(posedge clk) begin
        if (!rst_n) p_bus <= '0;
        else        p_bus <= {vs, hs, field, data};
    end

    // falling-edge sampling path
    always_ff @(negedge clk) begin
        if (!rst_n) n_bus <= '0;
        else        n_bus <= {vs, hs, field, data};
    end

    // edge selection and polarity normalisation
    always_comb begin
        sel_bus = clk_pol ? n_bus : p_bus;
        vs_act  = sel_bus[BUS_W-1] ^ sync_pol;
        hs_act  = sel_bus[BUS_W-2] ^ sync_pol;
        s_field = sel_bus[BUS_W-3];
        s_data  = sel_bus[DATA_W-1:0];
        vs_edge = vs_act && !vs_prev;
        hs_edge = hs_act && !hs_prev;
    end

    // previous active levels for assertion detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vs_prev <= 1'b0;
            hs_prev <= 1'b0;
        end else begin
            vs_prev <= vs_act;
            hs_prev <= hs_act;
        end
    end

    a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        hs_edge |=> !hs_edge);
endmodule

// File: rtl/vcap_ctrl.sv
// Module: vcap_ctrl
// Frame and line sequencer. It opens a frame on a horizontal sync assertion
// with field low that follows a vertical sync assertion. It then delays each
// line, takes count+1 samples and counts lines for the frame-track check.
// Assumes sync pulses are one cycle long (from vcap_front).
module vcap_ctrl
    import vcap_pkg::*;
#(
    parameter int DLY_W  = 8,
    parameter int CNT_W  = 12,
    parameter int LINE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              field,
    input  logic              vs_edge,
    input  logic              hs_edge,
    input  logic [DLY_W-1:0]  cfg_delay,
    input  logic [CNT_W-1:0]  cfg_count,
    input  logic [LINE_W-1:0] cfg_lines,
    output logic              take,
    output logic              line_start,
    output logic              ft_err
);
    localparam logic [DLY_W-1:0]  DLY_ONE  = DLY_W'(1);
    localparam logic [CNT_W-1:0]  CNT_ONE  = CNT_W'(1);
    localparam logic [LINE_W-1:0] LINE_ONE = LINE_W'(1);

    cap_state_t        st;
    logic [DLY_W-1:0]  dcnt;
    logic [CNT_W-1:0]  scnt;
    logic [LINE_W-1:0] line_cnt;
    logic              in_frame, start;

    // line start and sample strobe decode
    always_comb begin
        in_frame   = (st == S_LWAIT) || (st == S_DELAY) || (st == S_CAP);
        start      = en && hs_edge && !vs_edge && ((st == S_ARMED && !field) || in_frame);
        take       = en && !vs_edge &&
                     (start ? (cfg_delay == '0)
                            : ((st == S_DELAY && dcnt == '0) || st == S_CAP));
        line_start = start;
    end

    // sequencer, counters and frame-track flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= S_WAITVS;
            dcnt     <= '0;
            scnt     <= '0;
            line_cnt <= '0;
            ft_err   <= 1'b0;
        end else if (!en) begin
            st     <= S_WAITVS;
            ft_err <= 1'b0;
        end else if (vs_edge) begin
            if (in_frame && line_cnt != cfg_lines) ft_err <= 1'b1;
            st <= S_ARMED;
        end else if (start) begin
            if (st == S_ARMED)          line_cnt <= LINE_ONE;
            else if (line_cnt != '1)    line_cnt <= line_cnt + LINE_ONE;
            if (cfg_delay == '0) begin
                if (cfg_count == '0) st <= S_LWAIT;
                else begin
                    st   <= S_CAP;
                    scnt <= cfg_count - CNT_ONE;
                end
            end else begin
                st   <= S_DELAY;
                dcnt <= cfg_delay - DLY_ONE;
            end
        end else begin
            case (st)
                S_DELAY: begin
                    if (dcnt == '0) begin
                        if (cfg_count == '0) st <= S_LWAIT;
                        else begin
                            st   <= S_CAP;
                            scnt <= cfg_count - CNT_ONE;
                        end
                    end else begin
                        dcnt <= dcnt - DLY_ONE;
                    end
                end
                S_CAP: begin
                    if (scnt == '0) st <= S_LWAIT;
                    else            scnt <= scnt - CNT_ONE;
                end
                default: ;
            endcase
        end
    end

    a_r1_no_take_before_vsync: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_WAITVS) |-> !take);
    a_r3_stop_after_count: assert property (@(posedge clk) disable iff (!rst_n)
        (en && st == S_CAP && scnt == '0 && !hs_edge && !vs_edge) |=> (st == S_LWAIT));
    a_r10_ft_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (en && ft_err) |=> ft_err);
endmodule

// File: rtl/vcap_pack.sv
// Module: vcap_pack
// Forms FIFO words from samples. It zero-extends 8-bit samples, or in packed
// 8-bit mode pairs them with the earlier sample in the low byte. 16-bit samples
// pass through whole. A half-filled pair is dropped at each line start.
module vcap_pack #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pack,
    input  logic              wide,
    input  logic              take,
    input  logic              line_start,
    input  logic [DATA_W-1:0] data,
    output logic              push,
    output logic [DATA_W-1:0] push_data
);
    localparam int BYTE_W = DATA_W / 2;

    logic              half, eff_half, pack_mode;
    logic [BYTE_W-1:0] low_q;

    // word assembly
    always_comb begin
        pack_mode = pack && !wide;
        eff_half  = half && !line_start;
        if (wide) begin
            push      = take;
            push_data = data;
        end else if (pack_mode) begin
            push      = take && eff_half;
            push_data = {data[BYTE_W-1:0], low_q};
        end else begin
            push      = take;
            push_data = {{BYTE_W{1'b0}}, data[BYTE_W-1:0]};
        end
    end

    // pair state: holds the earlier byte of a packed pair
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            half  <= 1'b0;
            low_q <= '0;
        end else if (!pack_mode) begin
            half <= 1'b0;
        end else if (take) begin
            half <= !eff_half;
            if (!eff_half) low_q <= data[BYTE_W-1:0];
        end else if (line_start) begin
            half <= 1'b0;
        end
    end

    a_r7_wide_never_pairs: assert property (@(posedge clk) disable iff (!rst_n)
        wide |=> !half);
endmodule

// File: rtl/vcap_fifo.sv
// Module: vcap_fifo
// First-word-fall-through FIFO with an overrun flag. A push into a full FIFO
// with no pop is dropped. The flag is sticky until clr.
module vcap_fifo #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] rd_data,
    output logic              req,
    output logic              ovr_err
);
    localparam int AW = $clog2(DEPTH);
    localparam logic [AW:0]   FULL_CNT = (AW+1)'(DEPTH);
    localparam logic [AW-1:0] PTR_LAST = AW'(DEPTH - 1);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wptr, rptr;
    logic [AW:0]       cnt;
    logic              full, empty, pop_ok, push_ok;

    // occupancy decode
    always_comb begin
        full    = (cnt == FULL_CNT);
        empty   = (cnt == '0);
        pop_ok  = pop && !empty;
        push_ok = push && (!full || pop_ok);
        req     = !empty;
        rd_data = mem[rptr];
    end

    // storage write
    always_ff @(posedge clk) begin
        if (push_ok) mem[wptr] <= push_data;
    end

    // pointers, count and overrun flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr    <= '0;
            rptr    <= '0;
            cnt     <= '0;
            ovr_err <= 1'b0;
        end else begin
            if (push_ok) wptr <= (wptr == PTR_LAST) ? '0 : wptr + 1'b1;
            if (pop_ok)  rptr <= (rptr == PTR_LAST) ? '0 : rptr + 1'b1;
            if (push_ok && !pop_ok)      cnt <= cnt + 1'b1;
            else if (pop_ok && !push_ok) cnt <= cnt - 1'b1;
            if (clr)                     ovr_err <= 1'b0;
            else if (push && !push_ok)   ovr_err <= 1'b1;
        end
    end

    a_r8_req_after_push: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> req);
    a_r9_ovr_on_full_push: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop && !clr) |=> ovr_err);
    a_r9_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_err && !clr) |=> ovr_err);
endmodule

// File: rtl/vcap_port.sv
// Module: vcap_port (top)
// Frame-sync parallel video capture port: edge-selectable sampling front end,
// frame/line sequencer, packer and a 16-entry request FIFO. Configuration
// inputs are assumed static while en is high.
module vcap_port #(
    parameter int DATA_W     = 16,
    parameter int DLY_W      = 8,
    parameter int CNT_W      = 12,
    parameter int LINE_W     = 12,
    parameter int FIFO_DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              cfg_sync_pol,
    input  logic              cfg_clk_pol,
    input  logic              cfg_pack,
    input  logic              cfg_wide,
    input  logic [DLY_W-1:0]  cfg_delay,
    input  logic [CNT_W-1:0]  cfg_count,
    input  logic [LINE_W-1:0] cfg_lines,
    input  logic              vid_vs,
    input  logic              vid_hs,
    input  logic              vid_field,
    input  logic [DATA_W-1:0] vid_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              req,
    output logic              ft_err,
    output logic              ovr_err
);
    logic              s_field, vs_edge, hs_edge, take, line_start, push;
    logic [DATA_W-1:0] s_data, push_data;

    vcap_front #(.DATA_W(DATA_W)) u_front (
        .clk(clk), .rst_n(rst_n), .clk_pol(cfg_clk_pol), .sync_pol(cfg_sync_pol),
        .vs(vid_vs), .hs(vid_hs), .field(vid_field), .data(vid_data),
        .s_field(s_field), .s_data(s_data), .vs_edge(vs_edge), .hs_edge(hs_edge)
    );

    vcap_ctrl #(.DLY_W(DLY_W), .CNT_W(CNT_W), .LINE_W(LINE_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .en(en), .field(s_field),
        .vs_edge(vs_edge), .hs_edge(hs_edge),
        .cfg_delay(cfg_delay), .cfg_count(cfg_count), .cfg_lines(cfg_lines),
        .take(take), .line_start(line_start), .ft_err(ft_err)
    );

    vcap_pack #(.DATA_W(DATA_W)) u_pack (
        .clk(clk), .rst_n(rst_n), .pack(cfg_pack), .wide(cfg_wide),
        .take(take), .line_start(line_start), .data(s_data),
        .push(push), .push_data(push_data)
    );

    vcap_fifo #(.DATA_W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .clr(!en), .push(push), .push_data(push_data),
        .pop(rd_en), .rd_data(rd_data), .req(req), .ovr_err(ovr_err)
    );
endmodule

// File: tb/vcap_port_tb.sv
// Bench for vcap_port: table of frame scenarios walked by one loop, then
// directed tests for the start condition, disable and status clearing.
module vcap_port_tb;
    localparam int CLK_PERIOD = 10;
    localparam int LL         = 14;   // bus cycles per line
    localparam int NV         = 6;

    typedef struct packed {
        logic        spol;
        logic        cpol;
        logic        pack;
        logic        wide;
        logic [7:0]  dly;
        logic [11:0] cnt;
        logic [11:0] lines;
        logic [3:0]  nsent;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 1'b0, 1'b0, 8'd0, 12'd3, 12'd2, 4'd2},
        '{1'b1, 1'b0, 1'b0, 1'b0, 8'd2, 12'd2, 12'd3, 4'd3},
        '{1'b0, 1'b1, 1'b1, 1'b0, 8'd1, 12'd3, 12'd3, 4'd3},
        '{1'b0, 1'b0, 1'b1, 1'b1, 8'd0, 12'd1, 12'd4, 4'd3},
        '{1'b1, 1'b1, 1'b0, 1'b0, 8'd0, 12'd9, 12'd2, 4'd2},
        '{1'b0, 1'b0, 1'b1, 1'b0, 8'd3, 12'd2, 12'd1, 4'd2}
    };

    logic        clk = 1'b0;
    logic        rst_n, en, cfg_sync_pol, cfg_clk_pol, cfg_pack, cfg_wide;
    logic [7:0]  cfg_delay;
    logic [11:0] cfg_count, cfg_lines;
    logic        vid_vs, vid_hs, vid_field, rd_en;
    logic [15:0] vid_data, rd_data;
    logic        req, ft_err, ovr_err;

    int errors = 0;
    int checks = 0;
    logic [15:0] expw [64];
    int          nexp;
    logic        exp_ovr;

    vcap_port u_dut (
        .clk(clk), .rst_n(rst_n), .en(en), .cfg_sync_pol(cfg_sync_pol),
        .cfg_clk_pol(cfg_clk_pol), .cfg_pack(cfg_pack), .cfg_wide(cfg_wide),
        .cfg_delay(cfg_delay), .cfg_count(cfg_count), .cfg_lines(cfg_lines),
        .vid_vs(vid_vs), .vid_hs(vid_hs), .vid_field(vid_field), .vid_data(vid_data),
        .rd_en(rd_en), .rd_data(rd_data), .req(req), .ft_err(ft_err), .ovr_err(ovr_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not complete");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    task automatic check(input logic ok, input string req_tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req_tag, act, exp);
        end
    endtask

    function automatic logic [15:0] pix(input int l, input int p);
        logic [7:0] b;
        b = {4'(l), 4'(p)};
        return {b ^ 8'h5A, b};
    endfunction

    // one bus cycle: syncs held all cycle; data good only around the chosen edge
    task automatic drive(input logic vs, input logic hs, input logic fld,
                         input logic [15:0] d);
        @(posedge clk);
        #2;
        vid_vs = vs; vid_hs = hs; vid_field = fld;
        vid_data = cfg_clk_pol ? d : ~d;
        @(negedge clk);
        #2;
        vid_data = cfg_clk_pol ? ~d : d;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive(cfg_sync_pol, cfg_sync_pol, 1'b0, 16'h0);
    endtask

    task automatic vsync_pulse();
        drive(!cfg_sync_pol, cfg_sync_pol, 1'b0, 16'h0);
        drive(!cfg_sync_pol, cfg_sync_pol, 1'b0, 16'h0);
        idle(3);
    endtask

    // one line: hsync active for the first three cycles only
    task automatic send_line(input int l, input logic fld);
        for (int p = 0; p < LL; p++)
            drive(cfg_sync_pol, (p < 3) ? !cfg_sync_pol : cfg_sync_pol, fld, pix(l, p));
        idle(3);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; en = 1'b0; rd_en = 1'b0;
        idle(3);
        rst_n = 1'b1;
        idle(3);
    endtask

    task automatic build_exp(input vec_t v);
        int total;
        logic [7:0] b0;
        total = 0;
        nexp  = 0;
        for (int l = 0; l < int'(v.nsent); l++) begin
            for (int k = 0; k <= int'(v.cnt); k++) begin
                logic [15:0] w;
                logic        emit;
                w    = pix(l, int'(v.dly) + k);
                emit = 1'b1;
                if (v.wide) begin
                    emit = 1'b1;
                end else if (v.pack) begin
                    if (k % 2 == 0) begin
                        b0   = w[7:0];
                        emit = 1'b0;
                    end else begin
                        w = {w[7:0], b0};
                    end
                end else begin
                    w = {8'h00, w[7:0]};
                end
                if (emit) begin
                    if (nexp < 16) begin
                        expw[nexp] = w;
                        nexp++;
                    end
                    total++;
                end
            end
        end
        exp_ovr = (total > 16);
    endtask

    // drain the FIFO and compare with the expected list
    task automatic drain_check(input string tag);
        int got;
        got = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            rd_en = 1'b0;
            if (!req) break;
            if (got < nexp)
                check(rd_data == expw[got], tag, {16'h0, rd_data}, {16'h0, expw[got]});
            got++;
            rd_en = 1'b1;
        end
        rd_en = 1'b0;
        check(got == nexp, {tag, " word count"}, got, nexp);
    endtask

    initial begin
        rst_n = 1'b0; en = 1'b0; rd_en = 1'b0;
        cfg_sync_pol = 1'b0; cfg_clk_pol = 1'b0; cfg_pack = 1'b0; cfg_wide = 1'b0;
        cfg_delay = 8'd0; cfg_count = 12'd0; cfg_lines = 12'd1;
        vid_vs = 1'b0; vid_hs = 1'b0; vid_field = 1'b0; vid_data = 16'h0;
        do_reset();
        @(negedge clk);
        check(req == 1'b0, "R8 reset req", req, 0);
        check(ft_err == 1'b0, "R10 reset ft_err", ft_err, 0);
        check(ovr_err == 1'b0, "R9 reset ovr_err", ovr_err, 0);

        // table of frame scenarios (R2..R10)
        for (int k = 0; k < NV; k++) begin
            vec_t v;
            v = VECS[k];
            do_reset();
            cfg_sync_pol = v.spol; cfg_clk_pol = v.cpol; cfg_pack = v.pack;
            cfg_wide = v.wide; cfg_delay = v.dly; cfg_count = v.cnt; cfg_lines = v.lines;
            idle(4);
            en = 1'b1;
            idle(2);
            vsync_pulse();
            for (int l = 0; l < int'(v.nsent); l++) send_line(l, 1'b0);
            vsync_pulse();
            build_exp(v);
            @(negedge clk);
            check(ft_err == (v.nsent != v.lines[3:0]), $sformatf("R10 ft_err vec%0d", k),
                  ft_err, (v.nsent != v.lines[3:0]));
            check(ovr_err == exp_ovr, $sformatf("R9 ovr_err vec%0d", k), ovr_err, exp_ovr);
            drain_check($sformatf("R3 R4 R5 R6 R7 R8 data vec%0d", k));
            if (k == 3 || k == 4) begin
                en = 1'b0;
                idle(2);
                @(negedge clk);
                check(ft_err == 1'b0 && ovr_err == 1'b0,
                      $sformatf("R9 R10 cleared by disable vec%0d", k), {ft_err, ovr_err}, 0);
            end
        end

        // R1: disabled port ignores a full frame
        do_reset();
        cfg_sync_pol = 1'b0; cfg_clk_pol = 1'b0; cfg_pack = 1'b0; cfg_wide = 1'b0;
        cfg_delay = 8'd1; cfg_count = 12'd1; cfg_lines = 12'd1;
        idle(4);
        vsync_pulse();
        send_line(0, 1'b0);
        vsync_pulse();
        @(negedge clk);
        check(req == 1'b0, "R1 disabled port stores nothing", req, 0);

        // R1: lines without a vertical sync are ignored
        en = 1'b1;
        idle(2);
        send_line(1, 1'b0);
        send_line(2, 1'b0);
        @(negedge clk);
        check(req == 1'b0, "R1 no capture before vsync", req, 0);

        // R1: a line with field high does not open the frame; the next one does
        vsync_pulse();
        send_line(3, 1'b1);
        @(negedge clk);
        check(req == 1'b0, "R1 field high blocks frame start", req, 0);
        send_line(4, 1'b0);
        vsync_pulse();
        nexp = 2;
        expw[0] = {8'h00, pix(4, 1)};
        expw[1] = {8'h00, pix(4, 2)};
        expw[0][15:8] = 8'h00;
        expw[1][15:8] = 8'h00;
        @(negedge clk);
        check(ft_err == 1'b0, "R10 one-line frame matches", ft_err, 0);
        drain_check("R1 R3 capture after valid start");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule